// File: doc/BRIEF.md
# Emulated PHY Management Register Bank

This block stands in for a single-port Ethernet PHY that has no real line side. A host MAC manages it over the clause 22 MDIO serial interface exactly as it would a real transceiver. The block oversamples MDC and MDIO with its own system clock and decodes read and write frames sent to one fixed PHY address. It holds the standard control, status, identifier, advertisement and link-partner registers in their usual positions.

There is no link partner, so auto-negotiation is emulated. Any restart clears the complete flag and holds it low for a fixed number of clock cycles. The flag is then set, the link-partner register is loaded as a copy of the advertisement, and the link resolves to the best mode both sides share. A restart comes from reset release, from three external event pulses (soft PHY reset, digital reset, configuration reload), from a software reset, from the restart bit, or from enabling auto-negotiation. The resolved link state is also brought out on pins.

Top module: `vphy_mgmt`

## Requirements
- R1: A frame is accepted after at least 32 consecutive ones, start bits 0 then 1, opcode 10 (read) or 01 (write), a 5-bit PHY address, a 5-bit register address and two turnaround bits, all sent MSB first and sampled on MDC rising edges. On a read, `mdio_oe` stays low for the first turnaround bit, the block drives 0 for the second, then drives 16 data bits MSB first, and it releases the line after the last one. Any other opcode abandons the frame.
- R2: A frame whose PHY address differs from `PHY_ADDR` (default 1) never asserts `mdio_oe` and changes no register.
- R3: Register 0 (control) holds the writable bits 14 loopback, 13 speed 100, 12 auto-negotiation enable, 11 power down, 10 isolate, 8 full duplex and 7 collision test. Every other bit reads 0. The reset value is 0x3100.
- R4: Writing control bit 15 = 1 restores the control and advertisement defaults and restarts auto-negotiation. Writing bit 9 = 1 restarts auto-negotiation when the written bit 12 is 1. Bits 15 and 9 always read back as 0.
- R5: Register 1 (status) reads 0x7809, OR bit 5 = auto-negotiation complete, OR bit 2 = link up. It is read-only.
- R6: Registers 2 and 3 return the constants `ID_HI` (default 0x2A5C) and `ID_LO` (default 0x9E31) and are read-only.
- R7: Register 4 (advertisement) stores bits 8 (100 full), 7 (100 half), 6 (10 full) and 5 (10 half). Bits 4:0 read as 00001 and all other bits read 0. The reset value is 0x01E1.
- R8: Reads of addresses 6 to 31 return 0. Writes to addresses 1, 2, 3, 5 and 6 to 31 change nothing.
- R9: `an_complete` goes to 0 on the clock edge of a restart and returns to 1 on the `AN_HOLD_CYC`-th edge after it. Restarts come from reset release, from any `ext_restart` bit, from a bit-15 or bit-9 write, and from a write that sets bit 12 when it was 0. An MDIO write takes effect on the 4th clock edge after the MDC rising edge that samples its last data bit.
- R10: When auto-negotiation completes, register 5 becomes a copy of the register 4 read value. It reads 0 after a restart until completion, and while auto-negotiation is disabled.
- R11: On completion the link resolves, in priority order, to 100 full if advertisement bit 8 is set, else 100 half (bit 7), else 10 full (bit 6), else 10 half. `speed_100` and `full_duplex` show the result.
- R12: With bit 12 at 0, `an_complete` is 0, `link_up` is 1, and `speed_100` and `full_duplex` follow control bits 13 and 8. With bit 12 at 1 and negotiation still running, `link_up`, `speed_100` and `full_duplex` are 0.
- R13: A pulse on any `ext_restart` bit restores the control and advertisement defaults, clears register 5 and restarts auto-negotiation, all on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the MDC rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management data clock from the host |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Data driven onto the management line |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| ext_restart | input | 3 | Event pulses: soft PHY reset, digital reset, configuration reload |
| an_complete | output | 1 | Auto-negotiation complete (status bit 5) |
| link_up | output | 1 | Link status (status bit 2) |
| speed_100 | output | 1 | Resolved or forced 100 Mb/s |
| full_duplex | output | 1 | Resolved or forced full duplex |

## Verification
An `ext_restart` pulse takes effect on the next clock edge. An MDIO write takes effect on the fourth edge after the MDC rise that samples its last data bit. `an_complete` rises `AN_HOLD_CYC` edges after the restart edge. The reference model in the bench schedules each event for that exact edge and compares the four status pins at every falling clock edge. Read data appears about three clocks after each MDC rise, so the bench holds every MDC phase for eight clocks and samples the line just before the next rising edge. It reads registers only once negotiation has settled, so a status snapshot cannot race a completion.

// File: rtl/vphy_pkg.sv
package vphy_pkg;

    typedef enum logic [2:0] {
        FR_PRE,
        FR_START,
        FR_HDR,
        FR_TA,
        FR_DATA
    } fr_state_e;

    localparam logic [5:0]  PRE_ONES     = 6'd32;
    localparam logic [4:0]  RA_CTRL      = 5'd0;
    localparam logic [4:0]  RA_STAT      = 5'd1;
    localparam logic [4:0]  RA_ID_HI     = 5'd2;
    localparam logic [4:0]  RA_ID_LO     = 5'd3;
    localparam logic [4:0]  RA_ADV       = 5'd4;
    localparam logic [4:0]  RA_LP        = 5'd5;

    localparam logic [15:0] CTRL_WMASK   = 16'h7D80;
    localparam logic [15:0] CTRL_DEF     = 16'h3100;
    localparam logic [15:0] ADV_WMASK    = 16'h01E0;
    localparam logic [15:0] ADV_DEF      = 16'h01E0;
    localparam logic [15:0] ADV_SEL      = 16'h0001;
    localparam logic [15:0] STAT_FIXED   = 16'h7809;

    localparam int CB_SWRST  = 15;
    localparam int CB_SPEED  = 13;
    localparam int CB_AN_EN  = 12;
    localparam int CB_AN_RS  = 9;
    localparam int CB_DUPLEX = 8;

    // returns {speed_100, full_duplex}, best common mode first
    function automatic logic [1:0] an_resolve(input logic [15:0] adv);
        if (adv[8])      return 2'b11;
        else if (adv[7]) return 2'b10;
        else if (adv[6]) return 2'b01;
        else             return 2'b00;
    endfunction

endpackage

// File: rtl/vphy_mdio_frame.sv
module vphy_mdio_frame
    import vphy_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mdc,
    input  logic        mdio_i,
    input  logic [15:0] rd_data,
    output logic [4:0]  reg_addr,
    output logic        wr_en,
    output logic [15:0] wr_data,
    output logic        mdio_o,
    output logic        mdio_oe
);

    localparam int SYNC_W = 3;
    localparam int HDR_W  = 12;

    typedef struct packed {
        logic [SYNC_W-1:0] mdc_s;
        logic [1:0]        dio_s;
        fr_state_e         st;
        logic [5:0]        cnt;
        logic              rd;
        logic [HDR_W-1:0]  hdr;
        logic [15:0]       sh;
        logic [4:0]        ra;
        logic              oe;
        logic              o;
        logic              wr;
    } fr_t;

    fr_t q, d;
    logic             rise;
    logic             bitv;
    logic [HDR_W-1:0] full;

    always_comb begin
        d       = q;
        d.mdc_s = {q.mdc_s[SYNC_W-2:0], mdc};
        d.dio_s = {q.dio_s[0], mdio_i};
        d.wr    = 1'b0;
        rise    = q.mdc_s[1] & ~q.mdc_s[2];
        bitv    = q.dio_s[1];
        full    = {q.hdr[HDR_W-2:0], bitv};
        if (rise) begin
            unique case (q.st)
                FR_PRE: begin
                    if (bitv) begin
                        d.cnt = (q.cnt >= PRE_ONES) ? PRE_ONES : q.cnt + 6'd1;
                    end else if (q.cnt >= PRE_ONES) begin
                        d.st  = FR_START;
                        d.cnt = '0;
                    end else begin
                        d.cnt = '0;
                    end
                end
                FR_START: begin
                    d.st  = bitv ? FR_HDR : FR_PRE;
                    d.cnt = '0;
                end
                FR_HDR: begin
                    d.hdr = full;
                    if (q.cnt == 6'(HDR_W - 1)) begin
                        d.cnt = '0;
                        if (full[9:5] == PHY_ADDR &&
                            (full[11:10] == 2'b10 || full[11:10] == 2'b01)) begin
                            d.st = FR_TA;
                            d.rd = (full[11:10] == 2'b10);
                            d.ra = full[4:0];
                        end else begin
                            d.st = FR_PRE;
                        end
                    end else begin
                        d.cnt = q.cnt + 6'd1;
                    end
                end
                FR_TA: begin
                    if (q.cnt == 6'd0) begin
                        d.cnt = 6'd1;
                        if (q.rd) begin
                            d.oe = 1'b1;
                            d.o  = 1'b0;
                            d.sh = rd_data;
                        end
                    end else begin
                        d.st  = FR_DATA;
                        d.cnt = '0;
                        if (q.rd) begin
                            d.o  = q.sh[15];
                            d.sh = {q.sh[14:0], 1'b0};
                        end
                    end
                end
                FR_DATA: begin
                    if (q.rd) begin
                        if (q.cnt == 6'd15) begin
                            d.oe  = 1'b0;
                            d.o   = 1'b0;
                            d.st  = FR_PRE;
                            d.cnt = '0;
                        end else begin
                            d.o   = q.sh[15];
                            d.sh  = {q.sh[14:0], 1'b0};
                            d.cnt = q.cnt + 6'd1;
                        end
                    end else begin
                        d.sh = {q.sh[14:0], bitv};
                        if (q.cnt == 6'd15) begin
                            d.wr  = 1'b1;
                            d.st  = FR_PRE;
                            d.cnt = '0;
                        end else begin
                            d.cnt = q.cnt + 6'd1;
                        end
                    end
                end
                default: begin
                    d.st  = FR_PRE;
                    d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mdc_s: '0, dio_s: '0, st: FR_PRE, cnt: '0, rd: 1'b0,
                   hdr: '0, sh: '0, ra: '0, oe: 1'b0, o: 1'b0, wr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign reg_addr = q.ra;
    assign wr_en    = q.wr;
    assign wr_data  = q.sh;
    assign mdio_o   = q.o;
    assign mdio_oe  = q.oe;

    // R1: the first driven turnaround bit is a zero
    a_r1_ta_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !q.o);

    // R1: a write strobe lasts one clock
    a_r1_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);

    // R1: the line is never driven on a write frame
    a_r1_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> !q.oe);

endmodule

// File: rtl/vphy_aneg.sv
module vphy_aneg
    import vphy_pkg::*;
#(
    parameter int AN_HOLD_CYC = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        an_en,
    input  logic [15:0] adv,
    output logic        done,
    output logic [15:0] lp,
    output logic        res_spd,
    output logic        res_dup
);

    localparam int CW = (AN_HOLD_CYC > 2) ? $clog2(AN_HOLD_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(AN_HOLD_CYC - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          done;
        logic [15:0]   lp;
        logic          spd;
        logic          dup;
    } an_t;

    an_t q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.busy = 1'b1;
            d.cnt  = CNT_LOAD;
            d.done = 1'b0;
            d.lp   = '0;
        end else if (!an_en) begin
            d.busy = 1'b0;
            d.done = 1'b0;
            d.lp   = '0;
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy            = 1'b0;
                d.done            = 1'b1;
                d.lp              = adv;
                {d.spd, d.dup}    = an_resolve(adv);
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b1, cnt: CNT_LOAD, done: 1'b0, lp: '0,
                   spd: 1'b0, dup: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign lp      = q.lp;
    assign res_spd = q.spd;
    assign res_dup = q.dup;

    // R9: a restart always clears the complete flag
    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !q.done);

    // R9: completion only ends a running countdown
    a_r9_done_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(q.busy) && !q.busy);

    // R10: partner ability copies the advertisement at completion
    a_r10_lp_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> q.lp == $past(adv));

endmodule

// File: rtl/vphy_regs.sv
module vphy_regs
    import vphy_pkg::*;
#(
    parameter logic [15:0] ID_HI = 16'h2A5C,
    parameter logic [15:0] ID_LO = 16'h9E31
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  addr,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic [2:0]  ext_restart,
    input  logic        an_done,
    input  logic [15:0] an_lp,
    input  logic        res_spd,
    input  logic        res_dup,
    output logic [15:0] rd_data,
    output logic        an_restart,
    output logic        an_en_next,
    output logic [15:0] adv_rd,
    output logic        link_up,
    output logic        speed_100,
    output logic        full_duplex
);

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] adv;
    } rg_t;

    rg_t  q, d;
    logic ext_any;
    logic an_en;

    always_comb begin
        d          = q;
        an_restart = 1'b0;
        ext_any    = |ext_restart;
        if (ext_any) begin
            d.ctrl     = CTRL_DEF;
            d.adv      = ADV_DEF;
            an_restart = 1'b1;
        end else if (wr_en) begin
            if (addr == RA_CTRL) begin
                if (wr_data[CB_SWRST]) begin
                    d.ctrl     = CTRL_DEF;
                    d.adv      = ADV_DEF;
                    an_restart = 1'b1;
                end else begin
                    d.ctrl     = wr_data & CTRL_WMASK;
                    an_restart = wr_data[CB_AN_EN] &
                                 (wr_data[CB_AN_RS] | ~q.ctrl[CB_AN_EN]);
                end
            end else if (addr == RA_ADV) begin
                d.adv = wr_data & ADV_WMASK;
            end
        end
        an_en_next = d.ctrl[CB_AN_EN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctrl: CTRL_DEF, adv: ADV_DEF};
        end else begin
            q <= d;
        end
    end

    assign an_en       = q.ctrl[CB_AN_EN];
    assign adv_rd      = q.adv | ADV_SEL;
    assign link_up     = !an_en || an_done;
    assign speed_100   = an_en ? (an_done & res_spd) : q.ctrl[CB_SPEED];
    assign full_duplex = an_en ? (an_done & res_dup) : q.ctrl[CB_DUPLEX];

    always_comb begin
        unique case (addr)
            RA_CTRL:  rd_data = q.ctrl;
            RA_STAT:  rd_data = STAT_FIXED | {10'd0, an_done, 2'd0, link_up, 2'd0};
            RA_ID_HI: rd_data = ID_HI;
            RA_ID_LO: rd_data = ID_LO;
            RA_ADV:   rd_data = adv_rd;
            RA_LP:    rd_data = an_lp;
            default:  rd_data = '0;
        endcase
    end

    // R13: an external event restores the defaults
    a_r13_ext_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_restart) |=> (q.ctrl == CTRL_DEF) && (q.adv == ADV_DEF));

    // R8: writes outside the writable registers change nothing
    a_r8_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ext_any && addr != RA_CTRL && addr != RA_ADV)
        |=> $stable(q.ctrl) && $stable(q.adv));

    // R4: self-clearing bits never hold a stored 1
    a_r4_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !q.ctrl[CB_SWRST] && !q.ctrl[CB_AN_RS]);

endmodule

// File: rtl/vphy_mgmt.sv
module vphy_mgmt
    import vphy_pkg::*;
#(
    parameter logic [4:0]  PHY_ADDR    = 5'd1,
    parameter logic [15:0] ID_HI       = 16'h2A5C,
    parameter logic [15:0] ID_LO       = 16'h9E31,
    parameter int          AN_HOLD_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mdc,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic [2:0] ext_restart,
    output logic       an_complete,
    output logic       link_up,
    output logic       speed_100,
    output logic       full_duplex
);

    logic [4:0]  reg_addr;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        an_restart;
    logic        an_en_next;
    logic [15:0] adv_rd;
    logic        an_done;
    logic [15:0] an_lp;
    logic        res_spd;
    logic        res_dup;

    vphy_mdio_frame #(.PHY_ADDR(PHY_ADDR)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    vphy_regs #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .ext_restart (ext_restart),
        .an_done     (an_done),
        .an_lp       (an_lp),
        .res_spd     (res_spd),
        .res_dup     (res_dup),
        .rd_data     (rd_data),
        .an_restart  (an_restart),
        .an_en_next  (an_en_next),
        .adv_rd      (adv_rd),
        .link_up     (link_up),
        .speed_100   (speed_100),
        .full_duplex (full_duplex)
    );

    vphy_aneg #(.AN_HOLD_CYC(AN_HOLD_CYC)) u_aneg (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (an_restart),
        .an_en   (an_en_next),
        .adv     (adv_rd),
        .done    (an_done),
        .lp      (an_lp),
        .res_spd (res_spd),
        .res_dup (res_dup)
    );

    assign an_complete = an_done;

    // R12: with negotiation running the link is down
    a_r12_link_down_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (an_restart && an_en_next) |=> !link_up && !speed_100 && !full_duplex);

endmodule

// File: tb/test_vphy_mgmt.sv
module test_vphy_mgmt;

    localparam int          HALF   = 8;
    localparam int          AN     = 64;
    localparam logic [4:0]  MYPHY  = 5'd1;
    localparam logic [15:0] E_IDH  = 16'h2A5C;
    localparam logic [15:0] E_IDL  = 16'h9E31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mdc = 1'b0;
    logic       host_oe = 1'b0;
    logic       host_o = 1'b1;
    logic [2:0] ext = 3'b000;
    logic       mdio_o, mdio_oe, an_complete, link_up, speed_100, full_duplex;
    logic       mdio_bus;

    assign mdio_bus = mdio_oe ? mdio_o : (host_oe ? host_o : 1'b1);

    vphy_mgmt i_vphy_mgmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mdc         (mdc),
        .mdio_i      (mdio_bus),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .ext_restart (ext),
        .an_complete (an_complete),
        .link_up     (link_up),
        .speed_100   (speed_100),
        .full_duplex (full_duplex)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int oe_cnt = 0;
    bit done_flag = 0;

    // reference model state
    logic [15:0] m_ctrl, m_adv, m_lp;
    logic        m_done, m_rs, m_rd;
    int          m_left;
    int          wr_pend = 0;
    logic [4:0]  p_addr;
    logic [15:0] p_data;
    bit          started = 0;

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_link();
        return !m_ctrl[12] || m_done;
    endfunction

    function automatic logic [15:0] m_read(input logic [4:0] a);
        case (a)
            5'd0: return m_ctrl;
            5'd1: return 16'h7809 | (16'(m_done) << 5) | (16'(m_link()) << 2);
            5'd2: return E_IDH;
            5'd3: return E_IDL;
            5'd4: return m_adv | 16'h0001;
            5'd5: return m_lp;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic m_restart();
        m_left = AN;
        m_done = 0;
        m_lp   = 16'h0000;
    endtask

    task automatic m_defaults();
        m_ctrl = 16'h3100;
        m_adv  = 16'h01E0;
    endtask

    always @(posedge clk) begin
        if (m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
                m_done = 1;
                m_lp   = m_adv | 16'h0001;
                if (m_adv[8])      {m_rs, m_rd} = 2'b11;
                else if (m_adv[7]) {m_rs, m_rd} = 2'b10;
                else if (m_adv[6]) {m_rs, m_rd} = 2'b01;
                else               {m_rs, m_rd} = 2'b00;
            end
        end
        if (!rst_n) begin
            m_defaults();
            m_restart();
            m_rs = 0;
            m_rd = 0;
        end else if (ext != 3'b000) begin
            m_defaults();
            m_restart();
        end else if (wr_pend > 0) begin
            wr_pend--;
            if (wr_pend == 0) begin
                if (p_addr == 5'd0) begin
                    if (p_data[15]) begin
                        m_defaults();
                        m_restart();
                    end else begin
                        automatic logic old_en = m_ctrl[12];
                        m_ctrl = p_data & 16'h7D80;
                        if (m_ctrl[12] && (p_data[9] || !old_en)) m_restart();
                        else if (!m_ctrl[12]) begin
                            m_left = 0;
                            m_done = 0;
                            m_lp   = 16'h0000;
                        end
                    end
                end else if (p_addr == 5'd4) begin
                    m_adv = p_data & 16'h01E0;
                end
            end
        end
        started = 1;
    end

    // per-clock comparison of the status pins
    always @(negedge clk) begin
        if (mdio_oe) oe_cnt++;
        if (started && !done_flag) begin
            chk("R9 an_complete", 16'(an_complete), 16'(m_done));
            chk("R12 link_up", 16'(link_up), 16'(m_link()));
            chk("R11 R12 speed_100", 16'(speed_100),
                16'(m_ctrl[12] ? (m_done & m_rs) : m_ctrl[13]));
            chk("R11 R12 full_duplex", 16'(full_duplex),
                16'(m_ctrl[12] ? (m_done & m_rd) : m_ctrl[8]));
        end
    end

    task automatic mdc_cycle(input logic drv, input logic b, input logic arm, output logic smp);
        @(negedge clk);
        mdc = 1'b0;
        host_oe = drv;
        host_o = b;
        repeat (HALF - 1) @(negedge clk);
        smp = mdio_bus;
        mdc = 1'b1;
        if (arm) wr_pend = 4;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_bits(input int n, input logic [31:0] v);
        logic s;
        for (int i = n - 1; i >= 0; i--) mdc_cycle(1'b1, v[i], 1'b0, s);
    endtask

    task automatic mdio_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] dat);
        logic s;
        send_bits(32, 32'hFFFF_FFFF);
        send_bits(4, 32'b0101);
        send_bits(5, 32'(phy));
        send_bits(5, 32'(ra));
        send_bits(2, 32'b10);
        send_bits(15, 32'(dat[15:1]));
        p_addr = ra;
        p_data = dat;
        mdc_cycle(1'b1, dat[0], phy == MYPHY, s);
        mdc_cycle(1'b0, 1'b1, 1'b0, s);
    endtask

    task automatic mdio_read(input logic [4:0] phy, input logic [4:0] ra,
                             output logic [15:0] dat, output logic ta2);
        logic s;
        send_bits(32, 32'hFFFF_FFFF);
        send_bits(4, 32'b0110);
        send_bits(5, 32'(phy));
        send_bits(5, 32'(ra));
        mdc_cycle(1'b0, 1'b1, 1'b0, s);
        mdc_cycle(1'b0, 1'b1, 1'b0, ta2);
        for (int i = 15; i >= 0; i--) begin
            mdc_cycle(1'b0, 1'b1, 1'b0, s);
            dat[i] = s;
        end
        mdc_cycle(1'b0, 1'b1, 1'b0, s);
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] ra);
        logic [15:0] v;
        logic t;
        mdio_read(MYPHY, ra, v, t);
        chk(tag, v, m_read(ra));
    endtask

    task automatic pulse_ext(input int k);
        @(negedge clk);
        ext[k] = 1'b1;
        @(negedge clk);
        ext = 3'b000;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [15:0] v;
        logic t;
        int oe0;
        repeat (5) @(negedge clk);
        chk("R1 reset mdio_oe", 16'(mdio_oe), 16'h0);
        chk("R9 reset an_complete", 16'(an_complete), 16'h0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);

        // R1 R3 R5 R6 R7 R10 defaults after reset negotiation
        oe0 = oe_cnt;
        mdio_read(MYPHY, 5'd0, v, t);
        chk("R3 ctrl reset", v, 16'h3100);
        chk("R1 turnaround zero", 16'(t), 16'h0);
        chk("R1 oe asserted for read", 16'(oe_cnt > oe0), 16'h1);
        chk("R1 released after read", 16'(mdio_oe), 16'h0);
        mdio_read(MYPHY, 5'd1, v, t);
        chk("R5 status", v, 16'h782D);
        rd_chk("R6 id high", 5'd2);
        rd_chk("R6 id low", 5'd3);
        mdio_read(MYPHY, 5'd4, v, t);
        chk("R7 adv reset", v, 16'h01E1);
        mdio_read(MYPHY, 5'd5, v, t);
        chk("R10 partner mirror", v, 16'h01E1);

        // R8 unimplemented addresses
        rd_chk("R8 reg 9", 5'd9);
        rd_chk("R8 reg 31", 5'd31);

        // R7 mask, R11 resolution order, R4 restart bit
        mdio_write(MYPHY, 5'd4, 16'hFFFF);
        rd_chk("R7 adv mask", 5'd4);
        mdio_write(MYPHY, 5'd4, 16'h00E0);
        mdio_write(MYPHY, 5'd0, 16'h1200);
        repeat (AN + 10) @(negedge clk);
        rd_chk("R4 restart bit reads 0", 5'd0);
        rd_chk("R10 partner 100 half", 5'd5);
        mdio_write(MYPHY, 5'd4, 16'h0060);
        mdio_write(MYPHY, 5'd0, 16'h1200);
        repeat (AN + 10) @(negedge clk);
        rd_chk("R11 partner 10 full", 5'd5);
        mdio_write(MYPHY, 5'd4, 16'h0000);
        mdio_write(MYPHY, 5'd0, 16'h1200);
        repeat (AN + 10) @(negedge clk);
        rd_chk("R11 partner none", 5'd5);

        // R3 writable bits, R12 forced mode
        mdio_write(MYPHY, 5'd0, 16'h7FFF);
        repeat (AN + 10) @(negedge clk);
        rd_chk("R3 ctrl all bits", 5'd0);
        mdio_write(MYPHY, 5'd0, 16'h2100);
        rd_chk("R12 status forced", 5'd1);
        rd_chk("R10 partner cleared when off", 5'd5);
        mdio_write(MYPHY, 5'd0, 16'h0000);
        mdio_write(MYPHY, 5'd0, 16'h0200);
        rd_chk("R4 restart ignored when off", 5'd1);
        mdio_write(MYPHY, 5'd0, 16'h1000);
        repeat (AN + 10) @(negedge clk);
        rd_chk("R9 enable restarts", 5'd1);

        // R2 other PHY address
        oe0 = oe_cnt;
        mdio_write(5'd2, 5'd0, 16'h0000);
        mdio_read(5'd2, 5'd0, v, t);
        chk("R2 no drive other address", 16'(oe_cnt), 16'(oe0));
        rd_chk("R2 ctrl unchanged", 5'd0);

        // R8 read-only and unimplemented writes
        mdio_write(MYPHY, 5'd1, 16'h0000);
        mdio_write(MYPHY, 5'd2, 16'h0000);
        mdio_write(MYPHY, 5'd5, 16'h0000);
        mdio_write(MYPHY, 5'd7, 16'hFFFF);
        rd_chk("R8 status unchanged", 5'd1);
        rd_chk("R8 id unchanged", 5'd2);
        rd_chk("R8 partner unchanged", 5'd5);
        rd_chk("R8 reg 7 still zero", 5'd7);

        // R4 software reset
        mdio_write(MYPHY, 5'd4, 16'h0020);
        mdio_write(MYPHY, 5'd0, 16'h8000);
        repeat (AN + 10) @(negedge clk);
        rd_chk("R4 sw reset ctrl", 5'd0);
        rd_chk("R4 sw reset adv", 5'd4);

        // R13 external events
        for (int k = 0; k < 3; k++) begin
            mdio_write(MYPHY, 5'd0, 16'h0000);
            mdio_write(MYPHY, 5'd4, 16'h0040);
            pulse_ext(k);
            repeat (AN + 10) @(negedge clk);
            rd_chk("R13 ext ctrl default", 5'd0);
            rd_chk("R13 ext adv default", 5'd4);
        end

        repeat (10) @(negedge clk);
        finish_up();
    end

endmodule